// File: doc/BRIEF.md
# Serpentine Tiled Texture Address Generator

This block turns a pixel coordinate of a 32-bit-per-pixel texture into the byte offset of that pixel in a three-level tiled layout. The smallest unit is a 64-byte micro-tile of 4x4 pixels. Sixteen micro-tiles form a 1 KB sub-tile of 16x16 pixels. Four sub-tiles form a 4 KB tile of 32x32 pixels. Tiles are laid out in rows that snake through memory: one row runs left to right, the next runs right to left. Each tile also places its four sub-tiles in a different order depending on whether its tile row is even or odd.

A texture sampler or blit engine presents `x_i`, `y_i` and the image width in whole tiles, together with `valid_i`. One clock later it gets the offset on `offset_o`, with `valid_o` marking it. Within a tile, the half with local y below 16 is the bottom half, and the bottom-left sub-tile of an even-row tile is placed at the lowest address. The caller keeps `x_i` below 32 times the width.

Top module: `tformat_addr_gen`

## Requirements
- R1: While reset is held, and after it is released with no valid input, `valid_o` is 0 and `offset_o` is 0.
- R2: `valid_o` equals `valid_i` delayed by one clock, and `offset_o` carries the offset of the coordinate that was presented one clock earlier.
- R3: Offset bits [1:0] are 0, and bits [5:2] hold the pixel index within its micro-tile, (y mod 4)*4 + (x mod 4).
- R4: Offset bits [9:6] hold the micro-tile index within its sub-tile, ((y mod 16) div 4)*4 + ((x mod 16) div 4).
- R5: In an even tile row (bit 5 of y is 0), offset bits [11:10] hold the sub-tile slot: bottom-left 0, top-left 1, top-right 2, bottom-right 3. Here left means x mod 32 < 16 and bottom means y mod 32 < 16.
- R6: In an odd tile row the sub-tile slots are top-right 0, bottom-right 1, bottom-left 2, top-left 3.
- R7: In an even tile row the tile index, held in offset bits from 12 upwards, is ty*W + tx, where tx = x div 32, ty = y div 32 and W is the width in tiles.
- R8: In an odd tile row the tile index is ty*W + (W - 1 - tx), which mirrors the column.
- R9: A cycle with `valid_i` low leaves `offset_o` unchanged, whatever `x_i`, `y_i` and the width are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Coordinate is present |
| x_i | input | X_W (16) | Pixel column |
| y_i | input | Y_W (16) | Pixel row |
| width_tiles_i | input | WT_W (10) | Image width in 32-pixel tiles |
| valid_o | output | 1 | Offset is present |
| offset_o | output | OFF_W (33) | Byte offset of the pixel |

## Verification
The bench targets the points where the snake folds. The last column of an odd row must map to that row's first tile, and a design that skips the mirror puts it at the end of the row instead. Each of the eight sub-tile and row-parity combinations is checked on its own. Swapping the top and bottom halves, or using the even order on odd rows, moves an access by 1 KB or 2 KB. Swapping x and y inside a micro-tile or a sub-tile shows up as a transposed 4x4 block. Back-to-back coordinates expose a pipeline that lags by an extra stage or updates on idle cycles.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int unsigned PIX_LOG   = 2;  // 4x4 pixels per micro-tile
  localparam int unsigned UT_LOG    = 2;  // 4x4 micro-tiles per sub-tile
  localparam int unsigned SUB_LOG   = 1;  // 2x2 sub-tiles per tile
  localparam int unsigned TILE_LOG  = PIX_LOG + UT_LOG + SUB_LOG;  // 32 px
  localparam int unsigned BPP_LOG   = 2;  // 4 bytes per pixel
  localparam int unsigned INTRA_W   = 2*PIX_LOG + 2*UT_LOG + BPP_LOG;  // 10
  localparam int unsigned SLOT_W    = 2*SUB_LOG;                        // 2
  localparam int unsigned TILE_SH   = INTRA_W + SLOT_W;                 // 12

  typedef enum logic [1:0] {
    POS_BL = 2'b00,  // {right, top}
    POS_TL = 2'b01,
    POS_BR = 2'b10,
    POS_TR = 2'b11
  } sub_pos_e;
endpackage

// File: rtl/tt_intra_offset.sv
module tt_intra_offset
  import tt_pkg::*;
(
  input  logic [PIX_LOG+UT_LOG-1:0] xl_i,
  input  logic [PIX_LOG+UT_LOG-1:0] yl_i,
  output logic [INTRA_W-1:0]        off_o
);
  logic [2*PIX_LOG-1:0] pix_idx;
  logic [2*UT_LOG-1:0]  ut_idx;

  // raster order: row-major, y selects the row
  assign pix_idx = {yl_i[PIX_LOG-1:0], xl_i[PIX_LOG-1:0]};
  assign ut_idx  = {yl_i[PIX_LOG+UT_LOG-1:PIX_LOG], xl_i[PIX_LOG+UT_LOG-1:PIX_LOG]};
  assign off_o   = {ut_idx, pix_idx, {BPP_LOG{1'b0}}};
endmodule

// File: rtl/tt_subtile_slot.sv
module tt_subtile_slot
  import tt_pkg::*;
(
  input  logic              right_i,
  input  logic              top_i,
  input  logic              odd_row_i,
  output logic [SLOT_W-1:0] slot_o
);
  sub_pos_e pos;
  logic [SLOT_W-1:0] even_slot;

  assign pos = sub_pos_e'({right_i, top_i});

  always_comb begin
    unique case (pos)
      POS_BL:  even_slot = 2'd0;
      POS_TL:  even_slot = 2'd1;
      POS_TR:  even_slot = 2'd2;
      default: even_slot = 2'd3;  // POS_BR
    endcase
  end

  // odd-row order is the even order rotated by two places
  assign slot_o = odd_row_i ? even_slot + 2'd2 : even_slot;
endmodule

// File: rtl/tt_tile_index.sv
module tt_tile_index #(
  parameter int unsigned TX_W = 11,
  parameter int unsigned TY_W = 11,
  parameter int unsigned WT_W = 10,
  parameter int unsigned TI_W = TY_W + WT_W
) (
  input  logic [TX_W-1:0] tx_i,
  input  logic [TY_W-1:0] ty_i,
  input  logic [WT_W-1:0] width_i,
  output logic [TI_W-1:0] col_o,
  output logic [TI_W-1:0] idx_o
);
  logic [TI_W-1:0] row_base;
  logic [TI_W-1:0] tx_ext;
  logic [TI_W-1:0] w_ext;

  assign tx_ext   = TI_W'(tx_i);
  assign w_ext    = TI_W'(width_i);
  assign row_base = TI_W'(ty_i) * w_ext;
  assign col_o    = ty_i[0] ? (w_ext - TI_W'(1) - tx_ext) : tx_ext;
  assign idx_o    = row_base + col_o;
endmodule

// File: rtl/tformat_addr_gen.sv
module tformat_addr_gen
  import tt_pkg::*;
#(
  parameter int unsigned X_W   = 16,
  parameter int unsigned Y_W   = 16,
  parameter int unsigned WT_W  = 10,
  localparam int unsigned TX_W  = X_W - TILE_LOG,
  localparam int unsigned TY_W  = Y_W - TILE_LOG,
  localparam int unsigned TI_W  = TY_W + WT_W,
  localparam int unsigned OFF_W = TI_W + TILE_SH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [X_W-1:0]   x_i,
  input  logic [Y_W-1:0]   y_i,
  input  logic [WT_W-1:0]  width_tiles_i,
  output logic             valid_o,
  output logic [OFF_W-1:0] offset_o
);
  localparam int unsigned LOC_W = PIX_LOG + UT_LOG;

  logic [TX_W-1:0]    tx;
  logic [TY_W-1:0]    ty;
  logic               right, top, odd_row;
  logic [TI_W-1:0]    tile_col, tile_idx;
  logic [SLOT_W-1:0]  slot;
  logic [INTRA_W-1:0] intra;
  logic [OFF_W-1:0]   offset_d;

  assign tx      = x_i[X_W-1:TILE_LOG];
  assign ty      = y_i[Y_W-1:TILE_LOG];
  assign right   = x_i[TILE_LOG-1];
  assign top     = y_i[TILE_LOG-1];
  assign odd_row = ty[0];

  tt_intra_offset u_intra (
    .xl_i (x_i[LOC_W-1:0]),
    .yl_i (y_i[LOC_W-1:0]),
    .off_o(intra)
  );

  tt_subtile_slot u_slot (
    .right_i  (right),
    .top_i    (top),
    .odd_row_i(odd_row),
    .slot_o   (slot)
  );

  tt_tile_index #(
    .TX_W(TX_W), .TY_W(TY_W), .WT_W(WT_W), .TI_W(TI_W)
  ) u_tile (
    .tx_i   (tx),
    .ty_i   (ty),
    .width_i(width_tiles_i),
    .col_o  (tile_col),
    .idx_o  (tile_idx)
  );

  assign offset_d = {tile_idx, slot, intra};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      offset_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) offset_o <= offset_d;
    end
  end

  // R2: one-cycle valid latency
  a_r2_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  // R9: idle cycles leave the offset alone
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(offset_o));

  // R5: even row starts at the bottom-left sub-tile
  a_r5_bl_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !odd_row && !right && !top) |-> (slot == '0));

  // R6: odd row starts at the top-right sub-tile
  a_r6_tr_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && odd_row && right && top) |-> (slot == '0));

  // R8: the mirrored column stays inside the row
  a_r8_col_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (TI_W'(tx) < TI_W'(width_tiles_i))) |-> (tile_col < TI_W'(width_tiles_i)));
endmodule

// File: tb/tformat_addr_gen_test.sv
`timescale 1ns/1ps
module tformat_addr_gen_test;
  localparam int unsigned OFF_W = 33;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             valid_i = 1'b0;
  logic [15:0]      x_i = '0;
  logic [15:0]      y_i = '0;
  logic [9:0]       w_i = '0;
  logic             valid_o;
  logic [OFF_W-1:0] offset_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tformat_addr_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i),
    .x_i(x_i), .y_i(y_i), .width_tiles_i(w_i),
    .valid_o(valid_o), .offset_o(offset_o)
  );

  typedef struct packed {
    logic [15:0] x;
    logic [15:0] y;
    logic [9:0]  w;
    logic [31:0] expd;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{16'd0,   16'd0,  10'd4, 32'd0},      // R7 origin
    '{16'd1,   16'd0,  10'd4, 32'd4},      // R3 pixel x
    '{16'd0,   16'd1,  10'd4, 32'd16},     // R3 pixel y
    '{16'd4,   16'd0,  10'd4, 32'd64},     // R4 micro-tile x
    '{16'd0,   16'd4,  10'd4, 32'd256},    // R4 micro-tile y
    '{16'd0,   16'd16, 10'd4, 32'd1024},   // R5 top-left
    '{16'd16,  16'd16, 10'd4, 32'd2048},   // R5 top-right
    '{16'd16,  16'd0,  10'd4, 32'd3072},   // R5 bottom-right
    '{16'd32,  16'd0,  10'd4, 32'd4096},   // R7 next tile
    '{16'd0,   16'd32, 10'd4, 32'd30720},  // R8 R6 bottom-left odd
    '{16'd127, 16'd32, 10'd4, 32'd17612},  // R8 R6 bottom-right odd
    '{16'd16,  16'd48, 10'd4, 32'd28672},  // R6 top-right odd
    '{16'd0,   16'd63, 10'd4, 32'd32560},  // R6 top-left odd
    '{16'd37,  16'd70, 10'd2, 32'd20836}   // R7 even row two
  };

  function automatic longint ref_off(int x, int y, int w);
    int tx = x / 32, ty = y / 32, col, slot;
    bit rt = ((x / 16) % 2) == 1;
    bit tp = ((y / 16) % 2) == 1;
    col = (ty % 2 == 1) ? (w - 1 - tx) : tx;
    if (ty % 2 == 0) slot = (!rt && !tp) ? 0 : (!rt && tp) ? 1 : (rt && tp) ? 2 : 3;
    else             slot = (rt && tp) ? 0 : (rt && !tp) ? 1 : (!rt && !tp) ? 2 : 3;
    return longint'(ty * w + col) * 4096 + slot * 1024
         + (((y % 16) / 4) * 4 + (x % 16) / 4) * 64
         + ((y % 4) * 4 + (x % 4)) * 4;
  endfunction

  task automatic check(string req, longint act, longint expd);
    checks++;
    if (act != expd) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expd);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 during and after reset
    repeat (3) @(negedge clk);
    check("R1 valid in reset", longint'(valid_o), 0);
    check("R1 offset in reset", longint'(offset_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 valid idle", longint'(valid_o), 0);
    check("R1 offset idle", longint'(offset_o), 0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      x_i = VEC[i].x; y_i = VEC[i].y; w_i = VEC[i].w; valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
      check("R2 valid", longint'(valid_o), 1);
      check($sformatf("R3-R8 vec %0d", i), longint'(offset_o), longint'(VEC[i].expd));
      @(negedge clk);
      check("R2 valid drop", longint'(valid_o), 0);
    end

    // R9: idle inputs must not move the offset
    x_i = 16'd77; y_i = 16'd99; w_i = 10'd3; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check("R9 setup", longint'(offset_o), ref_off(77, 99, 3));
    for (int k = 0; k < 3; k++) begin
      x_i = 16'(k * 33 + 5); y_i = 16'(k * 41 + 2); w_i = 10'(k + 5);
      @(negedge clk);
      check("R9 hold", longint'(offset_o), ref_off(77, 99, 3));
      check("R9 valid low", longint'(valid_o), 0);
    end

    // R2 back-to-back sweep against the reference, checking one cycle late
    begin
      int px = -1, py = -1;
      for (int y = 0; y < 96; y += 3) begin
        for (int x = 0; x < 96; x += 5) begin
          x_i = 16'(x); y_i = 16'(y); w_i = 10'd3; valid_i = 1'b1;
          @(negedge clk);
          check("R2 pipelined valid", longint'(valid_o), 1);
          check("R2 R5 R6 R7 R8 sweep", longint'(offset_o), ref_off(x, y, 3));
          px = x; py = y;
        end
      end
      valid_i = 1'b0;
      @(negedge clk);
      check("R2 sweep end valid", longint'(valid_o), 0);
      check("R9 sweep end hold", longint'(offset_o), ref_off(px, py, 3));
    end

    // R8 single-tile-wide image: odd row mirror is identity
    x_i = 16'd31; y_i = 16'd33; w_i = 10'd1; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check("R8 width one", longint'(offset_o), ref_off(31, 33, 1));

    // R1 reset mid-stream
    x_i = 16'd64; y_i = 16'd64; w_i = 10'd4; valid_i = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async valid", longint'(valid_o), 0);
    check("R1 async offset", longint'(offset_o), 0);
    valid_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule